// File: doc/BRIEF.md
# Buffered-Compare PWM Timer Channel

This block is one channel of a general-purpose timer that produces a pulse-width-modulated waveform from a free-running counter. Two compare registers steer the waveform. The period register returns the counter to zero. The duty register sets the point in each period where the output goes high. A third register, the shadow, holds the next duty value. When buffering is on, the shadow is copied into the duty register at the exact step where the duty compare fires. Because of this, a new duty value written at any point in a period only takes effect at a waveform edge, and the output never shows a runt or a stretched pulse.

Software programs the channel through a small write port that carries an address, data and a valid strobe. The counter advances only on cycles where the external `tick` enable is high and the run bit is set, so any prescaler lives outside the block. Each compare register has a sticky match flag, which is cleared by writing a one to its bit.

Top module: `pwmt_channel`

## Requirements
- R1: After reset the counter, the duty, period and shadow registers, the output pin and both flags are 0, and the counter does not move until CTRL bit0 (run) is written to 1.
- R2: A step is a cycle with `tick` high and run set. On each step the counter either increments by one or clears. On every other cycle the counter and the pin hold their values.
- R3: On a step where the counter equals the period register, the counter becomes 0. With `tick` high every cycle, one period therefore lasts PERIOD+1 cycles, and with `tick` high every other cycle it lasts twice that.
- R4: On a step where the counter equals the duty register, and not the period register, the pin is 1 from the next cycle. With duty < period and `tick` high every cycle, the pin stays high for PERIOD−DUTY cycles and low for DUTY+1 cycles.
- R5: On a step where the counter equals the period register, the pin is 0 from the next cycle. This takes priority when both registers match on the same step.
- R6: When CTRL bit1 (buffer) is 1, every duty match copies the shadow into the duty register in the same cycle that the pin changes. The copy also happens when the duty and period registers match together. A new shadow value therefore shapes the period after the next duty match.
- R7: When CTRL bit1 is 0, writes to the duty address load the duty register directly, and the shadow contents never reach the duty register.
- R8: A step that matches the duty register sets flag A, and a step that matches the period register sets flag B. A write to the flag-clear address clears flag A when data bit0 is 1 and flag B when data bit1 is 1. A set in the same cycle as a clear takes priority.
- R9: The write port never applies back-pressure, so `wr_ready` is always 1. The address map is: 0 CTRL, 1 duty, 2 period, 3 shadow, 4 flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from an external prescaler |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted; always 1 |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W (16) | Write data |
| pwm_o | output | 1 | PWM waveform |
| flag_a_o | output | 1 | Sticky duty-match flag |
| flag_b_o | output | 1 | Sticky period-match flag |

## Verification
The bench builds the channel with the default CNT_W of 16 and keeps every compare value small. This keeps each period to tens of cycles, while the 16-bit compare and clear logic is still exercised unchanged. It measures the pin's high and low spans across a table of duty/period pairs, including duty 0 and adjacent duty/period values. Directed cases cover the one-period delay of a buffered duty update, a shadow that is ignored when buffering is off, coincident matches, a tick that is high every other cycle, and the clearing of each flag separately.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL    = 3'd0,
    ADDR_DUTY    = 3'd1,
    ADDR_PERIOD  = 3'd2,
    ADDR_SHADOW  = 3'd3,
    ADDR_FLAGCLR = 3'd4
  } reg_addr_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_BUF_BIT = 1;
  localparam int NUM_FLAGS    = 2;
endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic                 hit_a,
  output logic                 run,
  output logic                 buf_en,
  output logic [CNT_W-1:0]     duty,
  output logic [CNT_W-1:0]     period,
  output logic [CNT_W-1:0]     shadow,
  output logic [NUM_FLAGS-1:0] flag_clr
);
  logic sel_ctrl, sel_duty, sel_period, sel_shadow, sel_clr;

  always_comb begin
    sel_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
    sel_duty   = wr_en && (wr_addr == ADDR_DUTY);
    sel_period = wr_en && (wr_addr == ADDR_PERIOD);
    sel_shadow = wr_en && (wr_addr == ADDR_SHADOW);
    sel_clr    = wr_en && (wr_addr == ADDR_FLAGCLR);
    flag_clr   = sel_clr ? wr_data[NUM_FLAGS-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      buf_en <= 1'b0;
      period <= '0;
      shadow <= '0;
    end else begin
      if (sel_ctrl) begin
        run    <= wr_data[CTRL_RUN_BIT];
        buf_en <= wr_data[CTRL_BUF_BIT];
      end
      if (sel_period) period <= wr_data;
      if (sel_shadow) shadow <= wr_data;
    end
  end

  // Buffered transfer outranks a direct write landing in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)                duty <= '0;
    else if (hit_a && buf_en)  duty <= shadow;
    else if (sel_duty)         duty <= wr_data;
  end
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_a,
  output logic             hit_b
);
  always_comb begin
    hit_a = step && (cnt == duty);
    hit_b = step && (cnt == period);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (hit_b) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwmt_outstage.sv
module pwmt_outstage
  import pwmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hit_a,
  input  logic                 hit_b,
  input  logic [NUM_FLAGS-1:0] flag_clr,
  output logic                 pin,
  output logic [NUM_FLAGS-1:0] flags
);
  logic [NUM_FLAGS-1:0] hits;
  assign hits = {hit_b, hit_a};

  always_ff @(posedge clk) begin
    if (!rst_n)     pin <= 1'b0;
    else if (hit_b) pin <= 1'b0;
    else if (hit_a) pin <= 1'b1;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)           flags[g] <= 1'b0;
      else if (hits[g])     flags[g] <= 1'b1;
      else if (flag_clr[g]) flags[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [CNT_W-1:0]       wr_data,
  output logic                   pwm_o,
  output logic                   flag_a_o,
  output logic                   flag_b_o
);
  logic                 run, buf_en, step, hit_a, hit_b;
  logic [CNT_W-1:0]     duty, period, shadow, cnt;
  logic [NUM_FLAGS-1:0] flag_clr, flags;

  assign wr_ready = 1'b1;
  assign step     = tick && run;
  assign flag_a_o = flags[0];
  assign flag_b_o = flags[1];

  pwmt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_valid && wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .hit_a(hit_a),
    .run(run), .buf_en(buf_en), .duty(duty), .period(period),
    .shadow(shadow), .flag_clr(flag_clr)
  );

  pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .duty(duty),
    .period(period), .cnt(cnt), .hit_a(hit_a), .hit_b(hit_b)
  );

  pwmt_outstage u_out (
    .clk(clk), .rst_n(rst_n), .hit_a(hit_a), .hit_b(hit_b),
    .flag_clr(flag_clr), .pin(pwm_o), .flags(flags)
  );
endmodule

// File: rtl/pwmt_channel_chk.sv
module pwmt_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             run,
  input logic             buf_en,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] duty,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] shadow,
  input logic             pwm_o,
  input logic             flag_a_o,
  input logic             flag_b_o,
  input logic             wr_ready
);
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && run) |=> ($stable(cnt) && $stable(pwm_o)));

  a_r3_clear_on_period: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && cnt == period) |=> (cnt == '0));

  a_r4_pin_set_on_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && cnt == duty && cnt != period) |=> pwm_o);

  a_r5_pin_clear_on_period: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && cnt == period) |=> !pwm_o);

  a_r6_shadow_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && buf_en && cnt == duty) |=> (duty == $past(shadow)));

  a_r8_flag_a_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && cnt == duty) |=> flag_a_o);

  a_r8_flag_b_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && cnt == period) |=> flag_b_o);

  a_r9_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);
endmodule

bind pwmt_channel pwmt_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .buf_en(buf_en),
  .cnt(cnt), .duty(duty), .period(period), .shadow(shadow),
  .pwm_o(pwm_o), .flag_a_o(flag_a_o), .flag_b_o(flag_b_o),
  .wr_ready(wr_ready)
);

// File: tb/pwmt_channel_tb.sv
module pwmt_channel_tb;
  localparam int CNT_W = 16;
  localparam int LIMIT = 2000;

  typedef struct packed {
    logic [15:0] duty;
    logic [15:0] period;
    logic [15:0] hi;
    logic [15:0] lo;
  } vec_t;

  // R4: high = PERIOD-DUTY, low = DUTY+1 with tick every cycle
  localparam vec_t VECS[6] = '{
    '{16'd2,  16'd5,   16'd3,  16'd3},
    '{16'd0,  16'd3,   16'd3,  16'd1},
    '{16'd10, 16'd40,  16'd30, 16'd11},
    '{16'd1,  16'd2,   16'd1,  16'd2},
    '{16'd7,  16'd100, 16'd93, 16'd8},
    '{16'd0,  16'd1,   16'd1,  16'd1}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b1;
  logic             tick_alt = 1'b0;
  logic             wr_valid = 1'b0;
  logic             wr_ready;
  logic [2:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             pwm_o, flag_a_o, flag_b_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  pwmt_channel #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_o(pwm_o), .flag_a_o(flag_a_o), .flag_b_o(flag_b_o)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    cycles <= cycles + 1;
    tick   <= tick_alt ? ~tick : 1'b1;
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cycles > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      finish_run();
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [CNT_W-1:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // waits for the pin to go high, then counts cycles high
  task automatic measure_hi(output int hi);
    int t = 0;
    hi = 0;
    while (!pwm_o && t < LIMIT) begin @(negedge clk); t++; end
    while (pwm_o && hi < LIMIT) begin @(negedge clk); hi++; end
  endtask

  task automatic measure_lo(output int lo);
    lo = 0;
    while (!pwm_o && lo < LIMIT) begin @(negedge clk); lo++; end
  endtask

  initial begin
    int hi, lo, ones;
    @(negedge clk);
    do_reset();

    // R1 reset state and R9 ready
    check("R1 pin after reset", pwm_o, 0);
    check("R1 flag A after reset", flag_a_o, 0);
    check("R1 flag B after reset", flag_b_o, 0);
    check("R9 wr_ready", wr_ready, 1);

    // R1 no counting before run bit
    wr(3'd1, 16'd0);
    wr(3'd2, 16'd3);
    ones = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); ones += pwm_o; end
    check("R1 pin idle without run", ones, 0);
    check("R1 flag B idle without run", flag_b_o, 0);

    // table walk: R3 R4 R5 R7 (direct duty writes)
    for (int v = 0; v < 6; v++) begin
      do_reset();
      wr(3'd1, VECS[v].duty);
      wr(3'd2, VECS[v].period);
      wr(3'd0, 16'd1);
      measure_hi(hi);
      measure_lo(lo);
      check("R4 high span", hi, int'(VECS[v].hi));
      check("R3 R5 low span", lo, int'(VECS[v].lo));
    end

    // R2 R3: tick every other cycle doubles the spans
    do_reset();
    tick_alt = 1'b1;
    wr(3'd1, 16'd2);
    wr(3'd2, 16'd5);
    wr(3'd0, 16'd1);
    measure_hi(hi);
    measure_lo(lo);
    check("R2 high span at half tick rate", hi, 6);
    check("R3 low span at half tick rate", lo, 6);
    tick_alt = 1'b0;

    // R6 buffered duty: new shadow lands one period later
    do_reset();
    wr(3'd1, 16'd2);
    wr(3'd2, 16'd9);
    wr(3'd3, 16'd5);
    wr(3'd0, 16'd3);
    measure_hi(hi);
    check("R6 first period uses initial duty", hi, 7);
    wr(3'd3, 16'd8);
    measure_hi(hi);
    check("R6 second period uses first shadow", hi, 4);
    measure_hi(hi);
    check("R6 third period uses updated shadow", hi, 1);

    // R7 buffer off: shadow never reaches duty
    do_reset();
    wr(3'd1, 16'd2);
    wr(3'd2, 16'd9);
    wr(3'd3, 16'd7);
    wr(3'd0, 16'd1);
    measure_hi(hi);
    check("R7 duty unaffected by shadow p1", hi, 7);
    measure_hi(hi);
    check("R7 duty unaffected by shadow p2", hi, 7);

    // R5 R6 coincident match: pin stays low, transfer still occurs
    do_reset();
    wr(3'd1, 16'd4);
    wr(3'd2, 16'd4);
    wr(3'd3, 16'd1);
    wr(3'd0, 16'd3);
    ones = 0;
    for (int i = 0; i < 5; i++) begin ones += pwm_o; @(negedge clk); end
    check("R5 pin low on coincident match", ones, 0);
    measure_hi(hi);
    check("R6 transfer on coincident match", hi, 3);
    check("R8 flag A after coincident", flag_a_o, 1);
    check("R8 flag B after coincident", flag_b_o, 1);

    // R8 separate clearing of flags
    do_reset();
    wr(3'd1, 16'd2);
    wr(3'd2, 16'd5);
    wr(3'd0, 16'd1);
    repeat (10) @(negedge clk);
    check("R8 flag A set", flag_a_o, 1);
    check("R8 flag B set", flag_b_o, 1);
    wr(3'd0, 16'd0);
    wr(3'd4, 16'd1);
    check("R8 flag A cleared", flag_a_o, 0);
    check("R8 flag B kept", flag_b_o, 1);
    wr(3'd4, 16'd2);
    check("R8 flag B cleared", flag_b_o, 0);

    // R9 unmapped address has no effect on waveform
    wr(3'd7, 16'hFFFF);
    repeat (10) @(negedge clk);
    check("R9 unmapped write leaves run off", flag_b_o, 0);

    finish_run();
  end
endmodule